// File: doc/BRIEF.md
# CAN Nominal Bit Timer

This block produces the nominal bit timing for a CAN protocol engine. A prescaler divides the system clock into time quanta. A segment sequencer, advanced once per quantum, walks each bit through three segments: a one-quantum synchronisation slot, a combined propagation-plus-first-phase segment, and a second phase segment. It marks the end of the combined segment with a sample strobe, and at that strobe it latches the received bus level. It marks the end of the second phase segment with a transmit strobe, which is where the next bit to send begins.

All timing fields are held minus one. A bit therefore lasts `seg1_len + seg2_len + 3` quanta, where `seg1_len` and `seg2_len` are the field values. A falling edge on the receive line (recessive 1 to dominant 0) realigns the bit. If the host enables hard synchronisation, the edge restarts the bit. Otherwise the edge resynchronises the bit: a late edge lengthens the first phase and an early edge shortens the second, and the correction is capped by the jump width. The bus level is examined once per quantum, so every correction is a whole number of quanta. Frame logic above this block drives the hard-sync enable while the bus is idle, and uses the two strobes to pace receive and transmit.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_tick` is high for one clock every `cfg_brp + 1` system clocks.
- R2: With no falling edge on `rx_in`, `tx_pt` pulses once every `cfg_tseg1 + cfg_tseg2 + 3` quanta.
- R3: With no edge, `sample_pt` pulses on the quantum tick that comes `cfg_tseg1 + 2` ticks after a `tx_pt` tick. The next `tx_pt` follows `cfg_tseg2 + 1` ticks after that.
- R4: On each `sample_pt`, `rx_bit` takes the synchronised `rx_in` level (1 recessive, 0 dominant). `rx_bit` holds its value between sample points.
- R5: A falling edge with `hsync_en` high restarts the bit, and the quantum that holds the edge counts as the sync slot. The next `sample_pt` comes `cfg_tseg1 + 2` ticks after the edge is driven, with no `tx_pt` in between.
- R6: Without `hsync_en`, a falling edge in quantum c (counted from 0) of the combined segment delays the sample point by min(c+1, `cfg_sjw`+1) quanta.
- R7: Without `hsync_en`, a falling edge in quantum c of the second phase segment shortens it by min(`cfg_tseg2` - c, `cfg_sjw`+1) quanta.
- R8: Only the first resynchronising edge between two sample points takes effect. Later edges in the same span are ignored.
- R9: A falling edge inside the sync slot changes neither the sample point nor the bit length.
- R10: `sample_pt` and `tx_pt` rise only together with `tq_tick`, and never in the same clock.
- R11: While reset is active, `sample_pt` and `tx_pt` are low and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_brp | input | BRP_W | Quantum length in clocks, minus one |
| cfg_tseg1 | input | TS1_W | Propagation plus first phase length, minus one |
| cfg_tseg2 | input | TS2_W | Second phase length, minus one |
| cfg_sjw | input | SJW_W | Resynchronisation jump width, minus one |
| rx_in | input | 1 | Receive line, 1 recessive |
| hsync_en | input | 1 | Falling edges cause hard synchronisation |
| tq_tick | output | 1 | One-clock pulse per time quantum |
| sample_pt | output | 1 | Sample-point strobe |
| tx_pt | output | 1 | Transmit-point (bit start) strobe |
| rx_bit | output | 1 | Bus level latched at the last sample point |

## Verification
On every cycle, the assertions check the tick spacing, that the strobes line up with the tick and never overlap, that `rx_bit` changes only at a sample point and then takes the line level, that a lengthening stays within the jump width, and that the second phase never exceeds its programmed length. Only the directed scenarios show the actual quantum counts. These are the bit period, the sample-point position, the size of each lengthening or shortening for a given edge position and jump width, the restart on hard sync, the sync-slot edge that has no effect, and the suppression of a second edge.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/cbt_reset_sync.sv
module cbt_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cbt_quantum_gen.sv
module cbt_quantum_gen #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] cfg_brp,
  output logic             tick
);
  logic [BRP_W-1:0] div_q, div_d;

  always_comb begin
    tick  = (div_q == '0);
    div_d = tick ? cfg_brp : div_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R1: tick is one clock wide when a quantum spans several clocks
  p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cfg_brp != '0) |=> !tick);
endmodule

// File: rtl/cbt_edge_det.sv
module cbt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_in,
  output logic rx_s,
  output logic edge_fall
);
  logic meta_q, sync_q, lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d     = tick ? sync_q : lvl_q;
    edge_fall = tick & lvl_q & ~sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      lvl_q  <= 1'b1;
    end else begin
      meta_q <= rx_in;
      sync_q <= meta_q;
      lvl_q  <= lvl_d;
    end
  end

  assign rx_s = sync_q;
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
  import can_bt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             edge_fall,
  input  logic             hsync_en,
  input  logic [TS1_W-1:0] cfg_tseg1,
  input  logic [TS2_W-1:0] cfg_tseg2,
  input  logic [SJW_W-1:0] cfg_sjw,
  output logic             sample_pt,
  output logic             tx_pt
);
  localparam int EXT_W = SJW_W + 1;
  localparam int CNT_W = ((TS1_W > TS2_W) ? TS1_W : TS2_W) + 2;

  seg_e             seg_q, seg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] ext_q, ext_d;
  logic [TS2_W-1:0] tgt2_q, tgt2_d;
  logic             rs_done_q, rs_done_d;

  logic [CNT_W-1:0] jump_len;
  logic [CNT_W-1:0] late_err, early_err, step_len;
  logic [CNT_W-1:0] ext_use, tgt_use;
  logic             resync;

  always_comb begin
    seg_d     = seg_q;
    cnt_d     = cnt_q;
    ext_d     = ext_q;
    tgt2_d    = tgt2_q;
    rs_done_d = rs_done_q;
    sample_pt = 1'b0;
    tx_pt     = 1'b0;
    jump_len  = CNT_W'(cfg_sjw) + 1'b1;
    late_err  = cnt_q + 1'b1;
    early_err = CNT_W'(tgt2_q) - cnt_q;
    resync    = edge_fall & ~hsync_en & ~rs_done_q;
    step_len  = '0;
    ext_use   = CNT_W'(ext_q);
    tgt_use   = CNT_W'(tgt2_q);

    if (tick) begin
      if (edge_fall && hsync_en) begin
        seg_d     = SEG_TS1;
        cnt_d     = '0;
        ext_d     = '0;
        rs_done_d = 1'b0;
      end else begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_d = SEG_TS1;
            cnt_d = '0;
            ext_d = '0;
          end
          SEG_TS1: begin
            if (resync) begin
              step_len  = (late_err < jump_len) ? late_err : jump_len;
              ext_use   = step_len;
              ext_d     = EXT_W'(step_len);
              rs_done_d = 1'b1;
            end
            if (cnt_q == CNT_W'(cfg_tseg1) + ext_use) begin
              sample_pt = 1'b1;
              seg_d     = SEG_TS2;
              cnt_d     = '0;
              tgt2_d    = cfg_tseg2;
              rs_done_d = 1'b0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          SEG_TS2: begin
            if (resync && early_err != '0) begin
              step_len  = (early_err < jump_len) ? early_err : jump_len;
              tgt_use   = CNT_W'(tgt2_q) - step_len;
              tgt2_d    = TS2_W'(tgt_use);
              rs_done_d = 1'b1;
            end
            if (cnt_q >= tgt_use) begin
              tx_pt = 1'b1;
              seg_d = SEG_SYNC;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: begin
            seg_d = SEG_SYNC;
            cnt_d = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q     <= SEG_SYNC;
      cnt_q     <= '0;
      ext_q     <= '0;
      tgt2_q    <= '0;
      rs_done_q <= 1'b0;
    end else if (tick) begin
      seg_q     <= seg_d;
      cnt_q     <= cnt_d;
      ext_q     <= ext_d;
      tgt2_q    <= tgt2_d;
      rs_done_q <= rs_done_d;
    end
  end

  // R6: a lengthening is nonzero and within the jump width
  p_ext_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && edge_fall && !hsync_en && !rs_done_q && seg_q == SEG_TS1)
    |=> (ext_q != '0 && EXT_W'(ext_q) <= EXT_W'($past(cfg_sjw)) + 1'b1));

  // R7: the second phase only ever shrinks below its programmed length
  p_ph2_not_longer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_TS2) |-> (tgt2_q <= cfg_tseg2));

  // R8: once a resync is taken, no further correction before the sample point
  p_one_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rs_done_q && seg_q == SEG_TS1 && !(edge_fall && hsync_en))
    |=> $stable(ext_q));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic [TS1_W-1:0] cfg_tseg1,
  input  logic [TS2_W-1:0] cfg_tseg2,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic             rx_in,
  input  logic             hsync_en,
  output logic             tq_tick,
  output logic             sample_pt,
  output logic             tx_pt,
  output logic             rx_bit
);
  logic rst_sync_n;
  logic rx_s;
  logic edge_fall;
  logic rx_bit_q, rx_bit_d;

  cbt_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbt_quantum_gen #(.BRP_W(BRP_W)) u_tq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cfg_brp (cfg_brp),
    .tick    (tq_tick)
  );

  cbt_edge_det u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tq_tick),
    .rx_in     (rx_in),
    .rx_s      (rx_s),
    .edge_fall (edge_fall)
  );

  cbt_seg_fsm #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tq_tick),
    .edge_fall (edge_fall),
    .hsync_en  (hsync_en),
    .cfg_tseg1 (cfg_tseg1),
    .cfg_tseg2 (cfg_tseg2),
    .cfg_sjw   (cfg_sjw),
    .sample_pt (sample_pt),
    .tx_pt     (tx_pt)
  );

  always_comb rx_bit_d = sample_pt ? rx_s : rx_bit_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rx_bit_q <= 1'b1;
    else             rx_bit_q <= rx_bit_d;
  end

  assign rx_bit = rx_bit_q;

  // R10: strobes ride on the quantum tick
  p_strobe_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_pt || tx_pt) |-> tq_tick);

  // R10: sample and transmit points never coincide
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(sample_pt && tx_pt));

  // R4: the latched bit is the line level present at the sample point
  p_sample_capture_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sample_pt |=> (rx_bit == $past(rx_s)));

  // R4: the latched bit holds between sample points
  p_rxbit_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sample_pt |=> $stable(rx_bit));
endmodule

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  logic       clk;
  logic       rst_n;
  logic [5:0] cfg_brp;
  logic [3:0] cfg_tseg1;
  logic [2:0] cfg_tseg2;
  logic [1:0] cfg_sjw;
  logic       rx_in;
  logic       hsync_en;
  logic       tq_tick, sample_pt, tx_pt, rx_bit;

  int n_checks = 0;
  int n_fail   = 0;
  logic s_sp, s_tp;

  can_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_tseg1(cfg_tseg1),
    .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw), .rx_in(rx_in), .hsync_en(hsync_en),
    .tq_tick(tq_tick), .sample_pt(sample_pt), .tx_pt(tx_pt), .rx_bit(rx_bit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_tick();
    do @(negedge clk); while (!tq_tick);
    s_sp = sample_pt;
    s_tp = tx_pt;
  endtask

  task automatic align_tx();
    do next_tick(); while (!s_tp);
  endtask

  task automatic align_sample();
    do next_tick(); while (!s_sp);
  endtask

  task automatic ticks_to_sample(output int n, output bit saw_tx);
    n = 0; saw_tx = 0;
    do begin next_tick(); n++; if (s_tp) saw_tx = 1; end while (!s_sp && n < 100);
  endtask

  task automatic ticks_to_tx(output int n);
    n = 0;
    do begin next_tick(); n++; end while (!s_tp && n < 100);
  endtask

  task automatic reconfigure(input int brp, input int t1, input int t2, input int sjw);
    rst_n = 1'b0;
    rx_in = 1'b1;
    hsync_en = 1'b0;
    cfg_brp = 6'(brp); cfg_tseg1 = 4'(t1); cfg_tseg2 = 3'(t2); cfg_sjw = 2'(sjw);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    align_tx();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 sample_pt in reset", int'(sample_pt), 0);
    check("R11 tx_pt in reset", int'(tx_pt), 0);
    check("R11 rx_bit in reset", int'(rx_bit), 1);
  endtask

  task automatic t_prescaler(input int brp);
    int n;
    reconfigure(brp, 5, 2, 1);
    next_tick();
    n = 0;
    do begin @(negedge clk); n++; end while (!tq_tick);
    check("R1 clocks per quantum", n, brp + 1);
  endtask

  task automatic t_nominal(input int t1, input int t2);
    int a, b; bit tx_seen;
    reconfigure(3, t1, t2, 1);
    ticks_to_sample(a, tx_seen);
    check("R3 ticks tx to sample", a, t1 + 2);
    ticks_to_tx(b);
    check("R3 ticks sample to tx", b, t2 + 1);
    check("R2 bit length", a + b, t1 + t2 + 3);
    next_tick();
    @(negedge clk);
    check("R4 rx_bit recessive", int'(rx_bit), 1);
  endtask

  task automatic t_late(input int t1, input int sjw, input int c);
    int n, b, ext; bit tx_seen;
    reconfigure(3, t1, 3, sjw);
    repeat (c + 1) next_tick();
    rx_in = 1'b0;
    ticks_to_sample(n, tx_seen);
    rx_in = 1'b1;
    ext = (c + 1 < sjw + 1) ? c + 1 : sjw + 1;
    check("R6 late edge sample delay", (c + 1) + n, t1 + 2 + ext);
    @(negedge clk);
    check("R4 rx_bit dominant", int'(rx_bit), 0);
    ticks_to_tx(b);
    check("R6 phase2 unchanged after lengthening", b, 4);
  endtask

  task automatic t_early(input int t2, input int sjw);
    int b, sh;
    reconfigure(3, 5, t2, sjw);
    align_sample();
    rx_in = 1'b0;
    ticks_to_tx(b);
    rx_in = 1'b1;
    sh = (t2 < sjw + 1) ? t2 : sjw + 1;
    check("R7 early edge phase2 length", b, t2 + 1 - sh);
  endtask

  task automatic t_hard();
    int n; bit tx_seen;
    reconfigure(3, 6, 3, 0);
    hsync_en = 1'b1;
    repeat (3) next_tick();
    rx_in = 1'b0;
    ticks_to_sample(n, tx_seen);
    rx_in = 1'b1;
    hsync_en = 1'b0;
    check("R5 hard sync to sample", n, 6 + 2);
    check("R5 no tx_pt before sample", int'(tx_seen), 0);
  endtask

  task automatic t_sync_edge();
    int n, b; bit tx_seen;
    reconfigure(3, 5, 3, 3);
    rx_in = 1'b0;
    ticks_to_sample(n, tx_seen);
    rx_in = 1'b1;
    check("R9 sync-slot edge sample", n, 5 + 2);
    ticks_to_tx(b);
    check("R9 sync-slot edge bit length", n + b, 5 + 3 + 3);
  endtask

  task automatic t_one_resync();
    int n; bit tx_seen;
    reconfigure(3, 7, 3, 3);
    next_tick(); rx_in = 1'b0;
    next_tick(); rx_in = 1'b1;
    next_tick(); rx_in = 1'b0;
    ticks_to_sample(n, tx_seen);
    rx_in = 1'b1;
    check("R8 second edge ignored", 3 + n, 7 + 2 + 1);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_in = 1'b1; hsync_en = 1'b0;
    cfg_brp = 6'd3; cfg_tseg1 = 4'd5; cfg_tseg2 = 3'd2; cfg_sjw = 2'd1;
    t_reset();
    t_prescaler(3);
    t_prescaler(5);
    t_nominal(5, 2);
    t_nominal(2, 1);
    t_late(6, 3, 1);
    t_late(6, 0, 3);
    t_early(4, 3);
    t_early(4, 1);
    t_hard();
    t_sync_edge();
    t_one_resync();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule